// File: doc/BRIEF.md
# Flash Status Flag Generator

This block forms the read-back value of one NOR flash device with two banks while an internal program or erase routine is running. A controller tells it the current operation state, the address and data of that operation, and when a new operation begins. On every rising edge of the read strobe, the block captures one byte for the data bus.

If the read targets the bank that is busy, or the suspended block, the byte carries status flags. Otherwise it carries the array byte that arrives on `array_data_i`. A separate ready/busy output tracks the operation state. It stays low while the block runs its own timed abort of a program or erase aimed at a protected block.

The array, the command decoder and the cell programming all live outside this block.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `dq_o` is 8'h00 and `ready_o` is 1.
- R2: A read returns `array_data_i` unchanged in either of two cases: the state is idle (`op_state_i`=0), or the read address is in a different bank from `op_addr_i`. The bank is address bit 15.
- R3: In state program (`op_state_i`=1), a read from the busy bank returns status, and `ready_o` is 0. The status has bit 7 equal to the inverse of `prog_data_i[7]`, bit 5 = 0, bit 3 = 0 and bit 2 = 1. Bits 4, 1 and 0 come from `array_data_i`.
- R4: Bit 6 of a status read comes from a toggle flag that resets to 0 on `op_start_i`. The flag inverts after each status read in the program, erase, suspend-program, timeout and abort modes.
- R5: In state erase (`op_state_i`=2), a read from the busy bank gives bit 7 = 0, bit 5 = 0 and bit 3 = 1. Bit 2 comes from a second toggle flag that resets to 0 on `op_start_i` and inverts after each such read. `ready_o` is 0.
- R6: In state erase-suspended (`op_state_i`=3), a read from the suspended block gives bit 7 = 1, bit 6 = 1, bit 5 = 0 and bit 3 = 0. Bit 2 comes from the bit-2 toggle flag, which inverts after the read. `ready_o` is 1. The block is address bits 15:12.
- R7: In state erase-suspended, a read from any other block returns `array_data_i`, and `ready_o` stays 1.
- R8: In state program-during-suspend (`op_state_i`=4), the block reports exactly as in R3, including `ready_o`=0.
- R9: In the timeout states, bit 5 of a busy-bank read is 1, bit 6 keeps toggling and `ready_o` is 0. Program timeout is `op_state_i`=5: bit 7 is the inverse of `prog_data_i[7]`, bit 3 is 0 and bit 2 is 1. Erase timeout is `op_state_i`=6: bit 7 is 0, bit 3 is 1, and bit 2 toggles in the failing block but reads 1 elsewhere in the bank.
- R10: If `op_start_i` arrives with `op_prot_i`=1, the block runs an abort. The abort lasts PROG_US×CLK_MHZ cycles for a program (`op_erase_i`=0) and ERASE_US×CLK_MHZ cycles for an erase. During the abort, busy-bank reads report as in R3 and `ready_o` is 0. The abort takes priority over `op_state_i`. Afterwards the block returns to reading array data.
- R11: `dq_o` changes only on a clock edge where `rd_stb_i` rises, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| op_start_i | input | 1 | One-cycle pulse: a new operation begins |
| op_erase_i | input | 1 | With op_start_i: operation is an erase |
| op_prot_i | input | 1 | With op_start_i: target block is protected |
| op_state_i | input | 3 | Operation state code (0..6) |
| op_addr_i | input | ADDR_W | Address of the running operation |
| prog_data_i | input | 8 | Byte being programmed |
| rd_stb_i | input | 1 | Read strobe, sampled for a rising edge |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Array byte for the read address |
| dq_o | output | 8 | Captured read byte |
| ready_o | output | 1 | Ready (1) / busy (0) |

## Verification
Reads are made in three places: the busy block, another block of the busy bank, and the other bank. Together they separate the bank decode from the block decode. Each mode gets repeated reads, which show which of the two toggles advance and confirm that an operation start clears them.

Two program data bytes, with opposite bit 7, tell a true polling bit apart from a constant. The bench samples `ready_o` one cycle before and one cycle after each abort should end, which pins the abort length to the exact cycle.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG      = 3'd1,
        ST_ERASE     = 3'd2,
        ST_SUSP      = 3'd3,
        ST_SUSP_PROG = 3'd4,
        ST_TO_PROG   = 3'd5,
        ST_TO_ERASE  = 3'd6
    } op_state_e;

    typedef struct packed {
        logic t6;
        logic t2;
        logic stb;
    } tgl_regs_t;

    typedef struct packed {
        logic [7:0] dq;
    } out_regs_t;
endpackage

// File: rtl/fsg_abort_timer.sv
module fsg_abort_timer #(
    parameter int CLK_MHZ  = 200,
    parameter int PROG_US  = 1,
    parameter int ERASE_US = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic prot_i,
    input  logic erase_i,
    output logic active_o
);
    localparam int PROG_CYC  = CLK_MHZ * PROG_US;
    localparam int ERASE_CYC = CLK_MHZ * ERASE_US;
    localparam int CNT_W     = $clog2(ERASE_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = prot_i ? (erase_i ? ERASE_LD : PROG_LD) : '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);

    p_cnt_dec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q != '0 && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("abort counter did not count down");

    p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && prot_i) |=> active_o)
        else $error("protected start did not begin abort");
endmodule

// File: rtl/fsg_toggle_pair.sv
module fsg_toggle_pair (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic stb_i,
    input  logic flip6_i,
    input  logic flip2_i,
    output logic rise_o,
    output logic t6_o,
    output logic t2_o
);
    import fsg_pkg::*;

    tgl_regs_t r_d, r_q;

    assign rise_o = stb_i && !r_q.stb;

    always_comb begin
        r_d     = r_q;
        r_d.stb = stb_i;
        if (clr_i) begin
            r_d.t6 = 1'b0;
            r_d.t2 = 1'b0;
        end else if (rise_o) begin
            if (flip6_i) r_d.t6 = !r_q.t6;
            if (flip2_i) r_d.t2 = !r_q.t2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign t6_o = r_q.t6;
    assign t2_o = r_q.t2;

    p_t6_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o && flip6_i && !clr_i) |=> (t6_o != $past(t6_o)))
        else $error("DQ6 toggle did not invert");

    p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!t6_o && !t2_o))
        else $error("toggles not cleared on start");
endmodule

// File: rtl/fsg_status_encode.sv
module fsg_status_encode #(
    parameter int ADDR_W  = 16,
    parameter int BLK_LSB = 12
) (
    input  logic [2:0]        op_state_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [7:0]        prog_data_i,
    input  logic [7:0]        array_data_i,
    input  logic              t6_i,
    input  logic              t2_i,
    output logic [7:0]        rd_data_o,
    output logic              flip6_o,
    output logic              flip2_o,
    output logic              ready_o
);
    import fsg_pkg::*;

    localparam int BANK_BIT = ADDR_W - 1;

    logic      in_bank, in_blk;
    op_state_e st;

    assign st      = op_state_e'(op_state_i);
    assign in_bank = (rd_addr_i[BANK_BIT] == op_addr_i[BANK_BIT]);
    assign in_blk  = (rd_addr_i[ADDR_W-1:BLK_LSB] == op_addr_i[ADDR_W-1:BLK_LSB]);

    function automatic logic [7:0] pack_status(input logic b7, input logic b6,
                                               input logic b5, input logic b3,
                                               input logic b2, input logic [7:0] arr);
        return {b7, b6, b5, arr[4], b3, b2, arr[1:0]};
    endfunction

    always_comb begin
        rd_data_o = array_data_i;
        flip6_o   = 1'b0;
        flip2_o   = 1'b0;
        ready_o   = 1'b1;
        if (abort_i) begin
            ready_o = 1'b0;
            if (in_bank) begin
                rd_data_o = pack_status(!prog_data_i[7], t6_i, 1'b0, 1'b0, 1'b1, array_data_i);
                flip6_o   = 1'b1;
            end
        end else begin
            case (st)
                ST_PROG, ST_SUSP_PROG: begin
                    ready_o = 1'b0;
                    if (in_bank) begin
                        rd_data_o = pack_status(!prog_data_i[7], t6_i, 1'b0, 1'b0, 1'b1, array_data_i);
                        flip6_o   = 1'b1;
                    end
                end
                ST_ERASE: begin
                    ready_o = 1'b0;
                    if (in_bank) begin
                        rd_data_o = pack_status(1'b0, t6_i, 1'b0, 1'b1, t2_i, array_data_i);
                        flip6_o   = 1'b1;
                        flip2_o   = 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (in_blk) begin
                        rd_data_o = pack_status(1'b1, 1'b1, 1'b0, 1'b0, t2_i, array_data_i);
                        flip2_o   = 1'b1;
                    end
                end
                ST_TO_PROG: begin
                    ready_o = 1'b0;
                    if (in_bank) begin
                        rd_data_o = pack_status(!prog_data_i[7], t6_i, 1'b1, 1'b0, 1'b1, array_data_i);
                        flip6_o   = 1'b1;
                    end
                end
                ST_TO_ERASE: begin
                    ready_o = 1'b0;
                    if (in_bank) begin
                        rd_data_o = pack_status(1'b0, t6_i, 1'b1, 1'b1, in_blk ? t2_i : 1'b1,
                                                array_data_i);
                        flip6_o   = 1'b1;
                        flip2_o   = in_blk;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int ADDR_W   = 16,
    parameter int BLK_LSB  = 12,
    parameter int CLK_MHZ  = 200,
    parameter int PROG_US  = 1,
    parameter int ERASE_US = 100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic              op_prot_i,
    input  logic [2:0]        op_state_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [7:0]        prog_data_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [7:0]        array_data_i,
    output logic [7:0]        dq_o,
    output logic              ready_o
);
    import fsg_pkg::*;

    logic       abort, rise, t6, t2, flip6, flip2;
    logic [7:0] rd_data;
    out_regs_t  o_d, o_q;

    fsg_abort_timer #(.CLK_MHZ(CLK_MHZ), .PROG_US(PROG_US), .ERASE_US(ERASE_US)) u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(op_start_i),
        .prot_i(op_prot_i), .erase_i(op_erase_i), .active_o(abort));

    fsg_toggle_pair u_tgl (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(op_start_i), .stb_i(rd_stb_i),
        .flip6_i(flip6), .flip2_i(flip2), .rise_o(rise), .t6_o(t6), .t2_o(t2));

    fsg_status_encode #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_enc (
        .op_state_i(op_state_i), .abort_i(abort), .op_addr_i(op_addr_i),
        .rd_addr_i(rd_addr_i), .prog_data_i(prog_data_i), .array_data_i(array_data_i),
        .t6_i(t6), .t2_i(t2), .rd_data_o(rd_data), .flip6_o(flip6), .flip2_o(flip2),
        .ready_o(ready_o));

    always_comb begin
        o_d = o_q;
        if (rise) o_d.dq = rd_data;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) o_q <= '0;
        else         o_q <= o_d;
    end

    assign dq_o = o_q.dq;

    p_dq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_stb_i && !$past(rd_stb_i)) |=> $stable(dq_o))
        else $error("dq changed without a read");

    p_abort_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort |-> !ready_o)
        else $error("ready high during abort");

    p_timeout_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_state_i == 3'd5 || op_state_i == 3'd6) |-> !ready_o)
        else $error("ready high in timeout");

    p_timeout_dq5_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise && !abort && (op_state_i == 3'd5 || op_state_i == 3'd6)
         && rd_addr_i[ADDR_W-1] == op_addr_i[ADDR_W-1]) |=> dq_o[5])
        else $error("DQ5 low on timeout status read");

    p_susp_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!abort && op_state_i == 3'd3) |-> ready_o)
        else $error("ready low while suspended");
endmodule

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
    localparam int CLK_MHZ = 200;
    localparam int PROG_N  = CLK_MHZ * 1;
    localparam int ERASE_N = CLK_MHZ * 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0, op_erase = 1'b0, op_prot = 1'b0;
    logic [2:0]  op_state = 3'd0;
    logic [15:0] op_addr = 16'h1000;
    logic [7:0]  prog_data = 8'h80;
    logic        rd_stb = 1'b0;
    logic [15:0] rd_addr = 16'h0000;
    logic [7:0]  array_data = 8'hA5;
    logic [7:0]  dq;
    logic        ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit e6 = 0, e2 = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       stb_prev = 1'b0, cap = 1'b0;

    always #2.5 clk = ~clk;

    flash_status_gen #(.CLK_MHZ(CLK_MHZ)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start), .op_erase_i(op_erase),
        .op_prot_i(op_prot), .op_state_i(op_state), .op_addr_i(op_addr),
        .prog_data_i(prog_data), .rd_stb_i(rd_stb), .rd_addr_i(rd_addr),
        .array_data_i(array_data), .dq_o(dq), .ready_o(ready));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] st(input logic b7, input logic b6, input logic b5,
                                      input logic b3, input logic b2);
        return {b7, b6, b5, array_data[4], b3, b2, array_data[1:0]};
    endfunction

    // monitor: pops one expected byte per captured read
    always @(posedge clk) begin
        cap      <= rd_stb && !stb_prev;
        stb_prev <= rd_stb;
    end
    always @(negedge clk) begin
        if (cap && exp_q.size() > 0) begin
            check(tag_q.pop_front(), dq, exp_q.pop_front());
        end
    end

    // driver: one read, expected value pushed to the scoreboard
    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
        rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic start(input logic er, input logic pr);
        op_start = 1'b1; op_erase = er; op_prot = pr;
        @(negedge clk);
        op_start = 1'b0; op_prot = 1'b0;
        e6 = 0; e2 = 0;
    endtask

    task automatic set_state(input logic [2:0] s);
        op_state = s;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dq reset", dq, 8'h00);
        check("R1 ready reset", {7'd0, ready}, 8'h01);

        // idle reads and hold
        rd(16'h1234, 8'hA5, "R2 idle read");
        array_data = 8'h5A;
        repeat (3) @(negedge clk);
        check("R11 dq holds without strobe", dq, 8'hA5);
        array_data = 8'hA5;

        // program
        start(1'b0, 1'b0);
        set_state(3'd1);
        check("R3 ready low programming", {7'd0, ready}, 8'h00);
        rd(16'h1234, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1), "R3 program status");
        rd(16'h1234, st(1'b0, 1'b1, 1'b0, 1'b0, 1'b1), "R4 DQ6 toggles");
        rd(16'h9000, 8'hA5, "R2 other bank array");
        rd(16'h1000, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1), "R4 DQ6 back to 0");
        prog_data = 8'h3C;
        rd(16'h1000, st(1'b1, 1'b1, 1'b0, 1'b0, 1'b1), "R3 DQ7 inverse of bit7=0");
        set_state(3'd0);
        rd(16'h1234, 8'hA5, "R2 true data after program");

        // erase
        start(1'b1, 1'b0);
        set_state(3'd2);
        check("R5 ready low erasing", {7'd0, ready}, 8'h00);
        rd(16'h1000, st(1'b0, 1'b0, 1'b0, 1'b1, 1'b0), "R5 erase status");
        rd(16'h3000, st(1'b0, 1'b1, 1'b0, 1'b1, 1'b1), "R5 erase DQ2 toggles");

        // erase suspend (toggles now 0,0)
        set_state(3'd3);
        check("R6 ready high suspended", {7'd0, ready}, 8'h01);
        rd(16'h1000, st(1'b1, 1'b1, 1'b0, 1'b0, 1'b0), "R6 suspended block status");
        rd(16'h1000, st(1'b1, 1'b1, 1'b0, 1'b0, 1'b1), "R6 DQ2 toggles suspended");
        rd(16'h3000, 8'hA5, "R7 other block array");
        check("R7 ready high other block", {7'd0, ready}, 8'h01);

        // program during suspend (DQ6 still 0)
        prog_data = 8'h80;
        set_state(3'd4);
        check("R8 ready low suspend program", {7'd0, ready}, 8'h00);
        rd(16'h1234, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1), "R8 suspend-program status");

        // erase timeout
        start(1'b1, 1'b0);
        set_state(3'd6);
        check("R9 ready low erase timeout", {7'd0, ready}, 8'h00);
        rd(16'h1000, st(1'b0, 1'b0, 1'b1, 1'b1, 1'b0), "R9 erase timeout block");
        rd(16'h3000, st(1'b0, 1'b1, 1'b1, 1'b1, 1'b1), "R9 erase timeout other block");
        rd(16'h1000, st(1'b0, 1'b0, 1'b1, 1'b1, 1'b1), "R9 erase timeout DQ2 toggled");

        // program timeout
        start(1'b0, 1'b0);
        set_state(3'd5);
        rd(16'h1234, st(1'b0, 1'b0, 1'b1, 1'b0, 1'b1), "R9 program timeout status");
        rd(16'h1234, st(1'b0, 1'b1, 1'b1, 1'b0, 1'b1), "R9 program timeout DQ6");
        check("R9 ready low program timeout", {7'd0, ready}, 8'h00);
        set_state(3'd0);
        check("R2 ready high idle", {7'd0, ready}, 8'h01);

        // protected program abort
        start(1'b0, 1'b1);
        check("R10 ready low at abort", {7'd0, ready}, 8'h00);
        rd(16'h1234, st(1'b0, 1'b0, 1'b0, 1'b0, 1'b1), "R10 abort status");
        repeat (PROG_N - 3) @(negedge clk);
        check("R10 ready low last abort cycle", {7'd0, ready}, 8'h00);
        @(negedge clk);
        check("R10 ready high after program abort", {7'd0, ready}, 8'h01);
        rd(16'h1234, 8'hA5, "R10 array after abort");

        // protected erase abort
        start(1'b1, 1'b1);
        repeat (ERASE_N - 1) @(negedge clk);
        check("R10 ready low end of erase abort", {7'd0, ready}, 8'h00);
        @(negedge clk);
        check("R10 ready high after erase abort", {7'd0, ready}, 8'h01);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R11: %0d reads not captured, expected 0", exp_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule